// File: doc/BRIEF.md
# Level-Sensitive Two-Output Interrupt Controller

This block takes 32 level-sensitive interrupt request lines and presents them to a processor as two interrupt outputs. Software controls it through a small register bus: an address, a write strobe, write data, and read data that answers in the same cycle. Each source has an enable bit. Software never writes the enable vector directly. It sets enable bits by writing ones to one register and clears them by writing ones to another. A zero bit in either write leaves the matching enable bit alone.

A routing register sends each source to output 0 or to output 1. The top bit of the enable vector is also the master gate for the whole block: while it is clear, neither output can assert. The controller does not latch requests. A pending bit shows the sampled level of its line and drops as soon as the line drops. For dispatch, the block also gives the number of the lowest pending source on output 0, with a valid flag.

Top module: `lvl_intc`

## Requirements
- R1: After reset the enable vector and the routing register are all zeros, both `irq_o` bits are low and `pend_valid` is low.
- R2: Reading offset 0x30 returns the source lines as sampled at the previous clock edge. The value is not latched, so a bit reads 0 again one cycle after its line falls.
- R3: Writing offset 0x34 sets every enable bit whose write-data bit is 1. Writing offset 0x38 clears every enable bit whose write-data bit is 1. Zero bits in either write leave the enable bit unchanged. Reading 0x34 returns the enable vector, and reading 0x38 returns zero.
- R4: Enable bit 31 is the master gate and is also the enable of source 31. While it is clear, both status registers read zero and both `irq_o` bits stay low, whatever the other enable bits hold.
- R5: The routing register sits at offset 0x20 and reads back as written. Routing bit n = 0 sends source n to output 0, and routing bit n = 1 sends it to output 1. A source never appears in both status registers.
- R6: Offset 0x00 reads the output-0 status: level AND enable AND NOT routing, or zero while the master gate is clear. Offset 0x04 reads the output-1 status: level AND enable AND routing, gated the same way.
- R7: `irq_o[k]` is the OR of the output-k status bits, registered one clock after that status.
- R8: `pend_idx` is the position of the lowest set bit of the output-0 status, and `pend_valid` is 1 exactly when that status is non-zero. While `pend_valid` is 0, `pend_idx` is 0.
- R9: Writes to 0x00, 0x04, 0x30 or to any unmapped offset change nothing. Reads of unmapped offsets return zero.
- R10: Writing all ones to 0x38 clears every enable bit, including the master gate, so both outputs go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive request lines |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the address |
| irq_o | output | 2 | Interrupt outputs 0 and 1 |
| pend_idx | output | 5 | Lowest pending source on output 0 |
| pend_valid | output | 1 | Output 0 has a pending source |

## Verification
The main sweep walks a single active line across all 32 positions under three routings: all to output 0, all to output 1, and alternating. Each step shows whether a source lands on the right output, whether the pending index finds the right position, and whether any bit leaks into the other status. Multi-bit patterns, where several lines are high at once, show that the index picks the lowest set bit and not merely some set bit. The same patterns are then run with the master gate clear, and with partial enable vectors built up by set and clear writes. These runs separate gating and masking from the raw level readback, which has to keep showing the lines.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned N_SRC  = 32;
    localparam int unsigned N_OUT  = 2;
    localparam int unsigned IDX_W  = $clog2(N_SRC);
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned GLB    = N_SRC - 1;

    localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h38;

    typedef logic [N_SRC-1:0] vec_t;

    typedef struct packed {
        vec_t             lvl;
        vec_t             en;
        vec_t             route;
        logic [N_OUT-1:0] irq;
    } state_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  vec_t                       src_i,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  vec_t                       wdata,
    input  logic [N_OUT-1:0][N_SRC-1:0] stat,
    output vec_t                       lvl,
    output vec_t                       en,
    output vec_t                       route,
    output logic [N_OUT-1:0]           irq
);
    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = src_i;
        if (we) begin
            unique case (addr)
                OFS_SET:   st_d.en    = st_q.en | wdata;
                OFS_CLR:   st_d.en    = st_q.en & ~wdata;
                OFS_ROUTE: st_d.route = wdata;
                default:   ;
            endcase
        end
        for (int k = 0; k < int'(N_OUT); k++) begin
            st_d.irq[k] = |stat[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl   = st_q.lvl;
    assign en    = st_q.en;
    assign route = st_q.route;
    assign irq   = st_q.irq;
endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_pkg::*;
(
    input  vec_t                        lvl,
    input  vec_t                        en,
    input  vec_t                        route,
    output logic [N_OUT-1:0][N_SRC-1:0] stat
);
    vec_t live;
    assign live = en[GLB] ? (lvl & en) : '0;

    for (genvar k = 0; k < int'(N_OUT); k++) begin : g_out
        if (k == 0) begin : g_zero
            assign stat[k] = live & ~route;
        end else begin : g_one
            assign stat[k] = live & route;
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
(
    input  vec_t             vec,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx   = '0;
        valid = |vec;
        for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_i,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq_o,
    output logic [4:0]        pend_idx,
    output logic              pend_valid
);
    vec_t                        lvl_w, en_w, route_w;
    vec_t                        stat0_w, stat1_w;
    logic [N_OUT-1:0][N_SRC-1:0] stat_w;

    intc_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .stat  (stat_w),
        .lvl   (lvl_w),
        .en    (en_w),
        .route (route_w),
        .irq   (irq_o)
    );

    intc_route u_route (
        .lvl   (lvl_w),
        .en    (en_w),
        .route (route_w),
        .stat  (stat_w)
    );

    assign stat0_w = stat_w[0];
    assign stat1_w = stat_w[1];

    intc_prio u_prio (
        .vec   (stat0_w),
        .idx   (pend_idx),
        .valid (pend_valid)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_STAT0: bus_rdata = stat0_w;
            OFS_STAT1: bus_rdata = stat1_w;
            OFS_ROUTE: bus_rdata = route_w;
            OFS_LEVEL: bus_rdata = lvl_w;
            OFS_SET:   bus_rdata = en_w;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input vec_t              wdata,
    input vec_t              en,
    input vec_t              stat0,
    input vec_t              stat1,
    input logic [N_OUT-1:0]  irq,
    input logic [IDX_W-1:0]  idx,
    input logic              valid
);
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_SET) |=> ((en & $past(wdata)) == $past(wdata))); // R3
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CLR) |=> ((en & $past(wdata)) == '0)); // R3
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (addr == OFS_SET || addr == OFS_CLR)) |=> $stable(en)); // R9
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en[GLB] |=> (irq == '0)); // R4
    AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 & stat1) == '0)); // R5
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past({|stat1, |stat0}))); // R7
    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (stat0[idx] && ((stat0 & ((vec_t'(1) << idx) - vec_t'(1))) == '0))); // R8
    AST_IDX_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (stat0 == '0 && idx == '0)); // R8
endmodule

bind lvl_intc intc_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .en    (en_w),
    .stat0 (stat0_w),
    .stat1 (stat1_w),
    .irq   (irq_o),
    .idx   (pend_idx),
    .valid (pend_valid)
);

// File: tb/lvl_intc_bench.sv
`timescale 1ns/1ps
module lvl_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;
    logic [4:0]  pend_idx;
    logic        pend_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] en_m = '0;
    logic [31:0] route_m = '0;

    always #5 clk = ~clk;

    lvl_intc u_lvl_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .pend_idx(pend_idx), .pend_valid(pend_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] st(input int k, input logic [31:0] lv);
        logic [31:0] live;
        live = en_m[31] ? (lv & en_m) : 32'h0;
        return (k == 0) ? (live & ~route_m) : (live & route_m);
    endfunction

    function automatic logic [5:0] low(input logic [31:0] v);
        logic [5:0] r;
        r = '0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = {1'b1, 5'(i)};
        return r;
    endfunction

    task automatic apply(input logic [31:0] s);
        logic [31:0] d, e0, e1;
        logic [5:0]  lo;
        src_i = s;
        tick();
        e0 = st(0, s); e1 = st(1, s); lo = low(e0);
        rd(8'h30, d); chk("R2 level", d, s);
        rd(8'h00, d); chk("R6 stat0", d, e0);
        rd(8'h04, d); chk("R6 stat1", d, e1);
        chk("R8 index", {26'h0, pend_valid, pend_idx}, {26'h0, lo});
        tick();
        chk("R7 irq", {30'h0, irq_o}, {30'h0, |e1, |e0});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] routes [3];
        routes[0] = 32'h0; routes[1] = 32'hFFFF_FFFF; routes[2] = 32'hAAAA_AAAA;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        rd(8'h34, d); chk("R1 enable reset", d, 0);
        rd(8'h20, d); chk("R1 route reset", d, 0);
        chk("R1 outputs reset", {29'h0, irq_o, pend_valid}, 0);

        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h34, d); chk("R9 ignored writes keep enable", d, 0);
        rd(8'h20, d); chk("R9 ignored writes keep route", d, 0);
        rd(8'h10, d); chk("R9 unmapped read", d, 0);

        wr(8'h20, 32'hA5A5_0F0F); rd(8'h20, d); chk("R5 route readback", d, 32'hA5A5_0F0F);
        wr(8'h34, 32'h0000_00FF); rd(8'h34, d); chk("R3 set", d, 32'h0000_00FF);
        wr(8'h34, 32'h0000_FF00); rd(8'h34, d); chk("R3 set keeps", d, 32'h0000_FFFF);
        wr(8'h38, 32'h0000_000F); rd(8'h34, d); chk("R3 clear", d, 32'h0000_FFF0);
        rd(8'h38, d); chk("R3 clear reads zero", d, 0);
        en_m = 32'h0000_FFF0; route_m = 32'hA5A5_0F0F;
        apply(32'h0000_FFFF);   // R4: master gate clear
        chk("R4 gated irq", {30'h0, irq_o}, 0);

        wr(8'h34, 32'h8000_0000); en_m = 32'h8000_FFF0;
        apply(32'hFFFF_FFFF);
        apply(32'h0000_0F00);
        apply(32'h0);           // R2: level not latched

        wr(8'h34, 32'hFFFF_FFFF); en_m = 32'hFFFF_FFFF;
        for (int r = 0; r < 3; r++) begin
            wr(8'h20, routes[r]); route_m = routes[r];
            for (int s = 0; s < 32; s++) apply(32'h1 << s);
            apply(32'h0001_0100);
            apply(32'h8000_0000);
            apply(32'h7FFF_FFFE);
        end

        wr(8'h20, 32'h0); route_m = 32'h0;
        wr(8'h38, 32'h8000_0000); en_m = 32'h7FFF_FFFF;
        apply(32'hFFFF_FFFF);   // R4 master gate clear again
        wr(8'h34, 32'hFFFF_FFFF); en_m = 32'hFFFF_FFFF;
        apply(32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF); en_m = 32'h0;
        rd(8'h34, d); chk("R10 clear all", d, 0);
        tick();
        chk("R10 outputs low", {29'h0, irq_o, pend_valid}, 0);
        apply(32'hFFFF_FFFF);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule